// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the bus timing for an I2C master. A byte/bit engine above it hands it one command at a time: a START (also used for a repeated START), a single data bit, or a STOP. The generator then drives the open-drain enables for SCL and SDA. It times every phase in units of a prescaled tick, where the tick is the functional clock divided by a power of two. It senses the real SCL and SDA pins through a synchronizer. Because the high phase is only timed once SCL has been seen high, a slave that holds SCL low lengthens the bit instead of corrupting it.

Software provides five timing fields: a 3-bit prescale exponent, the high time, the low time, a combined setup/hold time for START and STOP, and the data-valid delay. Each of the four timing fields counts prescaled ticks. The engine receives single-cycle strobes at the moment SDA is changed, at the moment SDA is sampled (together with the sampled level), and when the current command completes. The fields are read live and must not change while `busy` is high. Dropping `enable` aborts any command at once and releases both lines.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `busy`, `op_done`, `drive_stb` and `sample_stb` are all 0.
- R2: A phase programmed for N ticks lasts exactly N·2^P functional clocks, where P = `cfg_prescale` ranges over 0..7. Field values are 1..63.
- R3: For a BIT or STOP command, `scl_oe` is 1 from the clock edge that accepts the command, for `cfg_low`·2^P clocks, and then drops to 0.
- R4: In that low phase, `drive_stb` pulses in the clock before edge `cfg_datavd`·2^P after acceptance, and SDA changes at that edge. Here `cfg_datavd` lies in 1..`cfg_low`. For a BIT command `sda_oe` becomes the inverse of `cmd_bit` (1 releases SDA, 0 pulls it low).
- R5: After SCL is released, the high phase is timed only once both synchronizer stages of the SCL pin read high. Without stretching, `scl_oe` stays 0 for 3 + `cfg_high`·2^P clocks. Each extra clock that the pin is held low adds one clock.
- R6: At the last clock of the high phase, `sample_stb` and `op_done` pulse together and `sample_bit` carries the synchronized SDA pin level. At the following edge `scl_oe` returns to 1.
- R7: START with SCL released (`scl_oe` = 0): `sda_oe` rises 1 + `cfg_sethold`·2^P clocks after acceptance. `scl_oe` rises `cfg_sethold`·2^P clocks after that, with `op_done` pulsing once.
- R8: START with SCL held low (repeated START): SDA is released at the data-valid point and SCL is released after `cfg_low`·2^P clocks. `sda_oe` rises 3 + `cfg_sethold`·2^P clocks after the SCL release, and `scl_oe` rises `cfg_sethold`·2^P clocks later.
- R9: STOP: `sda_oe` becomes 1 at the data-valid point and SCL is released as in R3. `sda_oe` falls 3 + `cfg_sethold`·2^P clocks after the SCL release, leaving both lines released and `busy` at 0.
- R10: While `enable` is 0, both enables and `busy` are 0 from the next edge, and commands are not accepted.
- R11: A command is accepted only when `enable` is 1 and `busy` is 0. Operation codes are 0 START, 1 BIT and 2 STOP; code 3 is not accepted. A command presented while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Master enable; 0 aborts and releases the bus |
| cfg_prescale | input | 3 | Tick = clock / 2^cfg_prescale |
| cfg_high | input | 6 | SCL high time in ticks |
| cfg_low | input | 6 | SCL low time in ticks |
| cfg_sethold | input | 6 | START/STOP setup and hold time in ticks |
| cfg_datavd | input | 6 | SDA change delay after SCL falls, in ticks |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 START, 1 BIT, 2 STOP |
| cmd_bit | input | 1 | Bit value for a BIT command |
| scl_in | input | 1 | SCL pin level |
| sda_in | input | 1 | SDA pin level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Command in progress |
| drive_stb | output | 1 | SDA change point |
| sample_stb | output | 1 | SDA sample point |
| sample_bit | output | 1 | Sampled SDA level, valid with sample_stb |
| op_done | output | 1 | Command complete |

## Verification
A wrong tick counter or prescaler phase shows up within one bit period. The time `scl_oe` or `sda_oe` holds a level then differs from the programmed count by a multiple of 2^P clocks, so each phase is measured edge by edge. A wrong phase state shows up as `sda_oe` changing while SCL is released, in the wrong direction, or with no `op_done`. The bench checks both the line levels and the strobes after every command. A stale synchronizer or ignored stretch shows up as a high phase shorter than the stretch it was given.

// File: rtl/i2c_tgen_pkg.sv
`timescale 1ns/1ps
package i2c_tgen_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOW,
    PH_RISE,
    PH_HIGH,
    PH_SETUP,
    PH_HOLD
  } phase_e;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_BIT   = 2'd1,
    OP_STOP  = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

endpackage

// File: rtl/i2c_tgen_presc.sv
`timescale 1ns/1ps
module i2c_tgen_presc #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] prescale,
  input  logic             restart,
  output logic             tick
);

  localparam int PC_W = (1 << PRE_W) - 1;

  logic [PC_W-1:0] pc_q, pc_d, pc_max;

  always_comb begin
    pc_max = PC_W'((32'd1 << prescale) - 32'd1);
    tick   = (pc_q == pc_max);
    if (restart || tick) pc_d = '0;
    else                 pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  AST_PC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_q <= pc_max) || $past(restart)); // R2

endmodule

// File: rtl/i2c_tgen_sync.sv
`timescale 1ns/1ps
module i2c_tgen_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] all_high
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] sh_q, sh_d;

    always_comb sh_d = {sh_q[STAGES-2:0], din[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '1;
      else        sh_q <= sh_d;
    end

    assign dout[g]     = sh_q[STAGES-1];
    assign all_high[g] = &sh_q;
  end

endmodule

// File: rtl/i2c_tgen_fsm.sv
`timescale 1ns/1ps
module i2c_tgen_fsm
  import i2c_tgen_pkg::*;
#(
  parameter int FIELD_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               tick,
  input  logic [FIELD_W-1:0] cfg_high,
  input  logic [FIELD_W-1:0] cfg_low,
  input  logic [FIELD_W-1:0] cfg_sethold,
  input  logic [FIELD_W-1:0] cfg_datavd,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic               cmd_bit,
  input  logic               scl_high,
  input  logic               sda_level,
  output logic               restart,
  output logic               scl_oe,
  output logic               sda_oe,
  output logic               busy,
  output logic               drive_stb,
  output logic               sample_stb,
  output logic               sample_bit,
  output logic               op_done
);

  phase_e             state_q, state_d;
  op_e                op_q, op_d;
  logic               bit_q, bit_d;
  logic               scl_q, scl_d;
  logic               sda_q, sda_d;
  logic [FIELD_W-1:0] cnt_q, cnt_d;
  logic [FIELD_W-1:0] target;
  logic               accept, last, drive_hit, smp, done;

  // Phase length selection and tick bookkeeping
  always_comb begin
    unique case (state_q)
      PH_LOW:            target = cfg_low;
      PH_SETUP, PH_HOLD: target = cfg_sethold;
      default:           target = cfg_high;
    endcase
    last      = tick && (cnt_q == target - 1'b1);
    drive_hit = (state_q == PH_LOW) && tick && (cnt_q == cfg_datavd - 1'b1);
    accept    = enable && (state_q == PH_IDLE) && cmd_valid && (cmd_op != OP_NONE);
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    bit_d   = bit_q;
    scl_d   = scl_q;
    sda_d   = sda_q;
    smp     = 1'b0;
    done    = 1'b0;
    if (!enable) begin
      state_d = PH_IDLE;
      scl_d   = 1'b0;
      sda_d   = 1'b0;
    end else begin
      unique case (state_q)
        PH_IDLE: begin
          if (accept) begin
            op_d  = op_e'(cmd_op);
            bit_d = cmd_bit;
            if (op_e'(cmd_op) == OP_START && !scl_q) begin
              state_d = PH_RISE;
            end else begin
              state_d = PH_LOW;
              scl_d   = 1'b1;
            end
          end
        end
        PH_LOW: begin
          if (drive_hit) begin
            unique case (op_q)
              OP_START: sda_d = 1'b0;
              OP_STOP:  sda_d = 1'b1;
              default:  sda_d = ~bit_q;
            endcase
          end
          if (last) begin
            scl_d   = 1'b0;
            state_d = PH_RISE;
          end
        end
        PH_RISE: begin
          if (scl_high) state_d = (op_q == OP_BIT) ? PH_HIGH : PH_SETUP;
        end
        PH_HIGH: begin
          if (last) begin
            smp     = 1'b1;
            done    = 1'b1;
            scl_d   = 1'b1;
            state_d = PH_IDLE;
          end
        end
        PH_SETUP: begin
          if (last) begin
            if (op_q == OP_START) begin
              sda_d   = 1'b1;
              state_d = PH_HOLD;
            end else begin
              sda_d   = 1'b0;
              done    = 1'b1;
              state_d = PH_IDLE;
            end
          end
        end
        PH_HOLD: begin
          if (last) begin
            scl_d   = 1'b1;
            done    = 1'b1;
            state_d = PH_IDLE;
          end
        end
        default: state_d = PH_IDLE;
      endcase
    end

    restart = (state_d != state_q);
    if (restart || state_q == PH_IDLE || state_q == PH_RISE) cnt_d = '0;
    else if (tick)                                           cnt_d = cnt_q + 1'b1;
    else                                                     cnt_d = cnt_q;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      op_q    <= OP_BIT;
      bit_q   <= 1'b1;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      bit_q   <= bit_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      cnt_q   <= cnt_d;
    end
  end

  assign scl_oe     = scl_q;
  assign sda_oe     = sda_q;
  assign busy       = (state_q != PH_IDLE);
  assign drive_stb  = enable && drive_hit;
  assign sample_stb = smp;
  assign sample_bit = sda_level;
  assign op_done    = done;

  AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_oe && !sda_oe && !busy)); // R10
  AST_HIGH_AFTER_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_HIGH && $past(state_q) == PH_RISE) |-> $past(scl_high)); // R5
  AST_SAMPLE_SCL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (!scl_oe && op_done)); // R6
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    drive_stb |-> scl_oe); // R4
  AST_OP_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(op_q)); // R11
  AST_START_LEAVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && op_q == OP_START) |=> (scl_oe && sda_oe)); // R7
  AST_STOP_LEAVES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && op_q == OP_STOP) |=> (!scl_oe && !sda_oe && !busy)); // R9

endmodule

// File: rtl/i2c_scl_timer.sv
`timescale 1ns/1ps
module i2c_scl_timer #(
  parameter int PRE_W   = 3,
  parameter int FIELD_W = 6,
  parameter int SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [PRE_W-1:0]   cfg_prescale,
  input  logic [FIELD_W-1:0] cfg_high,
  input  logic [FIELD_W-1:0] cfg_low,
  input  logic [FIELD_W-1:0] cfg_sethold,
  input  logic [FIELD_W-1:0] cfg_datavd,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic               cmd_bit,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               scl_oe,
  output logic               sda_oe,
  output logic               busy,
  output logic               drive_stb,
  output logic               sample_stb,
  output logic               sample_bit,
  output logic               op_done
);

  localparam int LINES = 2;

  logic             tick, restart;
  logic [LINES-1:0] pins, pins_sync, pins_high;

  assign pins = {sda_in, scl_in};

  i2c_tgen_presc #(.PRE_W(PRE_W)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .prescale (cfg_prescale),
    .restart  (restart),
    .tick     (tick)
  );

  i2c_tgen_sync #(.WIDTH(LINES), .STAGES(SYNC_N)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (pins),
    .dout     (pins_sync),
    .all_high (pins_high)
  );

  i2c_tgen_fsm #(.FIELD_W(FIELD_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .tick        (tick),
    .cfg_high    (cfg_high),
    .cfg_low     (cfg_low),
    .cfg_sethold (cfg_sethold),
    .cfg_datavd  (cfg_datavd),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_bit     (cmd_bit),
    .scl_high    (pins_high[0]),
    .sda_level   (pins_sync[1]),
    .restart     (restart),
    .scl_oe      (scl_oe),
    .sda_oe      (sda_oe),
    .busy        (busy),
    .drive_stb   (drive_stb),
    .sample_stb  (sample_stb),
    .sample_bit  (sample_bit),
    .op_done     (op_done)
  );

endmodule

// File: tb/i2c_scl_timer_test.sv
`timescale 1ns/1ps
module i2c_scl_timer_test;

  logic       clk = 1'b0;
  logic       rst_n, enable;
  logic [2:0] cfg_prescale;
  logic [5:0] cfg_high, cfg_low, cfg_sethold, cfg_datavd;
  logic       cmd_valid, cmd_bit;
  logic [1:0] cmd_op;
  logic       scl_oe, sda_oe, busy, drive_stb, sample_stb, sample_bit, op_done;
  logic       stretch, slave_pull;
  logic       scl_pin, sda_pin;

  int  checks = 0;
  int  errors = 0;
  int  done_cnt = 0;
  bit  smp_cap;
  bit  finished = 0;

  always #5 clk = ~clk;

  assign scl_pin = ~scl_oe & ~stretch;
  assign sda_pin = ~sda_oe & ~slave_pull;

  i2c_scl_timer uut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_prescale(cfg_prescale), .cfg_high(cfg_high), .cfg_low(cfg_low),
    .cfg_sethold(cfg_sethold), .cfg_datavd(cfg_datavd),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bit(cmd_bit),
    .scl_in(scl_pin), .sda_in(sda_pin),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .drive_stb(drive_stb),
    .sample_stb(sample_stb), .sample_bit(sample_bit), .op_done(op_done)
  );

  always @(posedge clk) begin
    if (op_done) done_cnt <= done_cnt + 1;
    if (sample_stb) smp_cap <= sample_bit;
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int p, input int h, input int l, input int sh, input int dv);
    cfg_prescale = 3'(p);
    cfg_high     = 6'(h);
    cfg_low      = 6'(l);
    cfg_sethold  = 6'(sh);
    cfg_datavd   = 6'(dv);
  endtask

  // Leaves the caller at the negedge after the accepting edge
  task automatic send_cmd(input int op, input bit b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 2'(op);
    cmd_bit   = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_start_idle(input string req, input int h, input int sc);
    int n;
    int d0;
    d0 = done_cnt;
    send_cmd(0, 1'b0);
    n = 0;
    while (!sda_oe) begin n++; @(negedge clk); end
    chk(req, n, 1 + h * sc);
    n = 0;
    while (!scl_oe) begin n++; @(negedge clk); end
    chk(req, n, h * sc);
    chk("R7", done_cnt - d0, 1);
  endtask

  task automatic t_bit(input bit b, input bit pull, input int s, input int l,
                       input int dv, input int h, input int sc, output int low_n);
    int n;
    int dpos;
    int d0;
    d0 = done_cnt;
    slave_pull = pull;
    stretch = 1'b1;
    send_cmd(1, b);
    n = 0;
    dpos = -1;
    while (scl_oe) begin
      n++;
      if (drive_stb && dpos < 0) dpos = n;
      @(negedge clk);
    end
    low_n = n;
    chk("R3", n, l * sc);
    chk("R4", dpos, dv * sc);
    chk("R4", int'(sda_oe), int'(!b));
    n = 0;
    while (!scl_oe) begin
      n++;
      if (n == s + 1) stretch = 1'b0;
      @(negedge clk);
    end
    chk("R5", n, 3 + s + h * sc);
    chk("R6", int'(smp_cap), int'(b & !pull));
    chk("R6", done_cnt - d0, 1);
    stretch = 1'b0;
    slave_pull = 1'b0;
  endtask

  task automatic t_rstart(input int l, input int h, input int sc);
    int n;
    send_cmd(0, 1'b0);
    n = 0;
    while (scl_oe) begin n++; @(negedge clk); end
    chk("R8", n, l * sc);
    chk("R8", int'(sda_oe), 0);
    n = 0;
    while (!sda_oe) begin n++; @(negedge clk); end
    chk("R8", n, 3 + h * sc);
    n = 0;
    while (!scl_oe) begin n++; @(negedge clk); end
    chk("R8", n, h * sc);
  endtask

  task automatic t_stop(input int l, input int h, input int sc);
    int n;
    send_cmd(2, 1'b0);
    n = 0;
    while (scl_oe) begin n++; @(negedge clk); end
    chk("R3", n, l * sc);
    chk("R9", int'(sda_oe), 1);
    n = 0;
    while (sda_oe) begin n++; @(negedge clk); end
    chk("R9", n, 3 + h * sc);
    chk("R9", int'(scl_oe), 0);
    chk("R9", int'(busy), 0);
  endtask

  task automatic t_ignore();
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 2'd3;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11", int'(busy), 0);
    chk("R11", int'(scl_oe), 1);
    send_cmd(1, 1'b1);
    cmd_valid = 1'b1;
    cmd_op    = 2'd2;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (scl_oe) @(negedge clk);
    while (!scl_oe) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R11", int'(busy), 0);
    repeat (10) @(negedge clk);
    chk("R11", int'(scl_oe), 1);
  endtask

  task automatic t_disable();
    send_cmd(1, 1'b0);
    repeat (2) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R10", int'(scl_oe), 0);
    chk("R10", int'(sda_oe), 0);
    chk("R10", int'(busy), 0);
    send_cmd(0, 1'b0);
    @(negedge clk);
    chk("R10", int'(busy), 0);
    chk("R10", int'(sda_oe), 0);
    enable = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    int low_n;
    rst_n = 1'b0;
    enable = 1'b1;
    cmd_valid = 1'b0;
    cmd_op = 2'd0;
    cmd_bit = 1'b0;
    stretch = 1'b0;
    slave_pull = 1'b0;
    set_cfg(0, 3, 6, 2, 3);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(scl_oe), 0);
    chk("R1", int'(sda_oe), 0);
    chk("R1", int'(busy), 0);
    chk("R1", int'(op_done | drive_stb | sample_stb), 0);
    repeat (3) @(negedge clk);

    t_start_idle("R7", 2, 1);
    t_bit(1'b1, 1'b0, 0, 6, 3, 3, 1, low_n);

    set_cfg(2, 2, 4, 2, 1);
    t_bit(1'b0, 1'b0, 0, 4, 1, 2, 4, low_n);
    chk("R2", low_n, 16);

    set_cfg(0, 3, 6, 2, 3);
    t_bit(1'b1, 1'b1, 5, 6, 3, 3, 1, low_n);
    t_rstart(6, 2, 1);
    t_ignore();
    t_stop(6, 2, 1);
    t_disable();

    set_cfg(7, 1, 3, 1, 1);
    t_start_idle("R2", 1, 128);

    repeat (5) @(negedge clk);
    report();
  end

endmodule